// File: doc/BRIEF.md
# Watchdog Timer with Low-Power Wake-Up and Debug Suspend

This block is a 16-bit up-counting watchdog for the system controller of a microcontroller. Software keeps it from expiring by servicing it. A service is a write that carries the stored password, followed by a second write that stores new settings and locks the register again. A completed service loads the counter with the reload byte in the upper half and zero in the lower half. The counter then advances once per prescaled tick. If it rolls over past its top value, the block issues a one-cycle reset request.

The same counter serves as the wake-up timer while the CPU sits in idle or sleep. When the count steps from the midpoint value 0x7FFF to 0x8000 and the low-power input is high, the block emits a one-cycle wake pulse. The longest wake interval is therefore half of the longest watchdog period.

The count can be stopped in two ways. A halt bit held in the control register stops it unconditionally. Three debug inputs stop it during a debug session when suspension is selected and the stop line is high.

Top module: `wdog_top`

## Requirements
- R1: After reset the count is 0xFF00, the register is locked, the end-of-init bit is 1, the stored password is 0x3C, and rst_req, wake and acc_err are 0.
- R2: A write while locked whose password field (bits 15:8) equals the stored password clears the lock and clears acc_err. It changes no other setting and not the count.
- R3: A write while locked whose password field differs from the stored password sets acc_err. The register stays locked and the count is unchanged. acc_err stays set until the next matching password write.
- R4: A write while unlocked that has the lock bit (bit 1) set is a modify write. It stores the reload byte (bits 23:16), the new password (bits 15:8), the halt bit (bit 2) and the end-of-init bit (bit 0), and it locks the register. Two clock edges after the write edge the count equals {reload, 8'h00}. This holds even while the count is stopped.
- R5: A write while unlocked with the lock bit clear is rejected. It sets acc_err, locks the register, and stores nothing.
- R6: While running, the count rises by exactly one on each clock edge where tick is high, and holds when tick is low.
- R7: A tick at count 0xFFFF produces rst_req high for exactly one cycle and reloads the count to {reload, 8'h00}.
- R8: A tick taking the count from 0x7FFF to 0x8000 produces a one-cycle wake pulse if low_power is high, and no pulse if low_power is low.
- R9: With the halt bit set the count holds and no rst_req is raised, whatever the debug inputs are.
- R10: With halt clear the count runs unless dbg_enable, dbg_suspend and dbg_stop are all high, in which case it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled count enable, one cycle per step |
| wr_en | input | 1 | Control-register write strobe |
| wr_data | input | 32 | Write word: bit0 end-of-init, bit1 lock, bit2 halt, bits15:8 password, bits23:16 reload |
| low_power | input | 1 | CPU is in idle or sleep |
| dbg_enable | input | 1 | Debug session enabled |
| dbg_suspend | input | 1 | Debugger selects watchdog suspension |
| dbg_stop | input | 1 | Debug stop line from the trigger logic |
| count | output | 16 | Current counter value |
| rst_req | output | 1 | One-cycle reset request on overflow |
| wake | output | 1 | One-cycle wake-up pulse at the midpoint crossing |
| locked | output | 1 | Control register is locked |
| endinit | output | 1 | Stored end-of-init bit |
| acc_err | output | 1 | Sticky access-error flag |

## Verification
The counter runs through both of its notable crossings: 0x7FFF to 0x8000 with low_power high and then low, which shows that the wake pulse depends on the mode input, and 0xFFFF with a reload byte of 0xFF, which shows that the overflow reloads rather than wraps to zero. The debug inputs go through the four rows of the run/stop table. The halt bit is set with debug inputs that would otherwise let the count run, which shows that halt takes priority. The access port receives a wrong password, a right one, a modify write missing its lock bit, and a password change followed by use of the old password, which separates matching, rejection and storage.

// File: rtl/wdog_pkg.sv
// Shared widths, write-word field positions and the control-register type
// for the watchdog. Assumes the reload field sits in the top bits of the counter.
package wdog_pkg;
    parameter int CNT_W = 16;
    parameter int REL_W = 8;
    parameter int PW_W  = 8;
    parameter int DW    = 32;

    localparam int EI_BIT   = 0;
    localparam int LOCK_BIT = 1;
    localparam int HALT_BIT = 2;
    localparam int PW_LSB   = 8;
    localparam int REL_LSB  = PW_LSB + PW_W;
    localparam int LOW_W    = CNT_W - REL_W;

    typedef struct packed {
        logic [REL_W-1:0] rel;
        logic [PW_W-1:0]  pw;
        logic             halt;
        logic             endinit;
    } ctrl_t;
endpackage

// File: rtl/wdog_access.sv
// Password-gated access to the control register.
// Locked: a write that carries the stored password unlocks; a mismatch flags an error.
// Unlocked: the next write is the modify write. With its lock bit set it stores the
// settings and requests a counter reload. Without it, it is rejected. Either way the
// register locks again.
module wdog_access
    import wdog_pkg::*;
#(
    parameter logic [REL_W-1:0] RST_REL = 8'hFF,
    parameter logic [PW_W-1:0]  RST_PW  = 8'h3C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output ctrl_t         ctrl,
    output logic          locked,
    output logic          acc_err,
    output logic          svc
);
    logic [PW_W-1:0]  w_pw;
    logic [REL_W-1:0] w_rel;
    logic             w_lock;
    logic             pw_hit;
    logic             pw_miss;
    logic             mod_ok;
    logic             mod_bad;

    // Decode the write word and classify the access.
    always_comb begin
        w_pw    = wr_data[PW_LSB +: PW_W];
        w_rel   = wr_data[REL_LSB +: REL_W];
        w_lock  = wr_data[LOCK_BIT];
        pw_hit  = wr_en && locked && (w_pw == ctrl.pw);
        pw_miss = wr_en && locked && (w_pw != ctrl.pw);
        mod_ok  = wr_en && !locked && w_lock;
        mod_bad = wr_en && !locked && !w_lock;
    end

    // Lock bit: cleared by a password match, set again by any modify attempt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b1;
        else if (pw_hit)
            locked <= 1'b0;
        else if (mod_ok || mod_bad)
            locked <= 1'b1;
    end

    // Sticky access error: set on mismatch or a bad modify, cleared by a match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_err <= 1'b0;
        else if (pw_hit)
            acc_err <= 1'b0;
        else if (pw_miss || mod_bad)
            acc_err <= 1'b1;
    end

    // Stored settings: updated only by an accepted modify write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.rel     <= RST_REL;
            ctrl.pw      <= RST_PW;
            ctrl.halt    <= 1'b0;
            ctrl.endinit <= 1'b1;
        end else if (mod_ok) begin
            ctrl.rel     <= w_rel;
            ctrl.pw      <= w_pw;
            ctrl.halt    <= wr_data[HALT_BIT];
            ctrl.endinit <= wr_data[EI_BIT];
        end
    end

    // Service pulse: one cycle after a completed service sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)
            svc <= 1'b0;
        else
            svc <= mod_ok;
    end

    AST_RELOCK_AFTER_MODIFY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !locked) |=> locked); // R4
    AST_MISS_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && locked && (wr_data[PW_LSB +: PW_W] != ctrl.pw)) |=> (locked && acc_err)); // R3
    AST_MATCH_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && locked && (wr_data[PW_LSB +: PW_W] == ctrl.pw)) |=> (!locked && !acc_err)); // R2
    AST_BAD_MODIFY_KEEPS_SETTINGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !locked && !wr_data[LOCK_BIT]) |=> ($stable(ctrl) && acc_err)); // R5
endmodule

// File: rtl/wdog_gate.sv
// Run/stop decision for the counter. Halt always stops. During a debug session
// with suspension selected, the debug stop line stops the count.
// Assumes tick is already a one-cycle enable from a prescaler.
module wdog_gate (
    input  logic halt,
    input  logic dbg_enable,
    input  logic dbg_suspend,
    input  logic dbg_stop,
    input  logic tick,
    output logic run,
    output logic step
);
    logic dbg_hold;

    // Combine the halt bit and the debug table into a step enable.
    always_comb begin
        dbg_hold = dbg_enable && dbg_suspend && dbg_stop;
        run      = !halt && !dbg_hold;
        step     = run && tick;
    end
endmodule

// File: rtl/wdog_counter.sv
// Up-counter with reload, overflow reset request and midpoint wake pulse.
// A service reload has priority over a step. Both event outputs are registered.
// Assumes CNT_W > REL_W.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter logic [REL_W-1:0] RST_REL = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [REL_W-1:0] rel,
    input  logic             low_power,
    output logic [CNT_W-1:0] cnt,
    output logic             rst_req,
    output logic             wake
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] MID = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] RST_CNT = {RST_REL, {LOW_W{1'b0}}};

    logic [CNT_W-1:0] reload_val;
    logic             at_top;
    logic             at_mid;

    // Reload value and crossing detectors.
    always_comb begin
        reload_val = {rel, {LOW_W{1'b0}}};
        at_top     = step && !load && (cnt == TOP);
        at_mid     = step && !load && (cnt == MID);
    end

    // Counter: reload on service or overflow, otherwise step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= RST_CNT;
        else if (load || at_top)
            cnt <= reload_val;
        else if (step)
            cnt <= cnt + 1'b1;
    end

    // Overflow reset request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req <= 1'b0;
        else
            rst_req <= at_top;
    end

    // Wake pulse at the midpoint crossing, only in a low-power mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake <= 1'b0;
        else
            wake <= at_mid && low_power;
    end

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R7
    AST_RST_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt == reload_val)); // R7
    AST_WAKE_NEEDS_LP: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(low_power)); // R8
    AST_WAKE_AT_MID: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (cnt == MID + 1'b1)); // R8
    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cnt)); // R6
    AST_SERVICE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == {$past(rel), {LOW_W{1'b0}}})); // R4
endmodule

// File: rtl/wdog_top.sv
// Watchdog top: access control, run gate and counter.
// Assumes wr_en, tick and the debug inputs are synchronous to clk.
module wdog_top
    import wdog_pkg::*;
#(
    parameter logic [REL_W-1:0] RST_REL = 8'hFF,
    parameter logic [PW_W-1:0]  RST_PW  = 8'h3C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             low_power,
    input  logic             dbg_enable,
    input  logic             dbg_suspend,
    input  logic             dbg_stop,
    output logic [CNT_W-1:0] count,
    output logic             rst_req,
    output logic             wake,
    output logic             locked,
    output logic             endinit,
    output logic             acc_err
);
    ctrl_t ctrl;
    logic  svc;
    logic  run;
    logic  step;

    wdog_access #(.RST_REL(RST_REL), .RST_PW(RST_PW)) u_access (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .locked  (locked),
        .acc_err (acc_err),
        .svc     (svc)
    );

    wdog_gate u_gate (
        .halt        (ctrl.halt),
        .dbg_enable  (dbg_enable),
        .dbg_suspend (dbg_suspend),
        .dbg_stop    (dbg_stop),
        .tick        (tick),
        .run         (run),
        .step        (step)
    );

    wdog_counter #(.RST_REL(RST_REL)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .load      (svc),
        .rel       (ctrl.rel),
        .low_power (low_power),
        .cnt       (count),
        .rst_req   (rst_req),
        .wake      (wake)
    );

    // Export the stored end-of-init bit.
    always_comb endinit = ctrl.endinit;

    AST_HALT_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.halt |=> !rst_req); // R9
    AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.halt && !svc) |=> $stable(count)); // R9
    AST_DEBUG_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_enable && dbg_suspend && dbg_stop && !svc) |=> $stable(count)); // R10
endmodule

// File: tb/sim_wdog_top.sv
module sim_wdog_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        low_power = 1'b0;
    logic        dbg_enable = 1'b0;
    logic        dbg_suspend = 1'b0;
    logic        dbg_stop = 1'b0;
    logic [15:0] count;
    logic        rst_req, wake, locked, endinit, acc_err;

    int checks = 0;
    int fails = 0;
    int wake_seen = 0;
    int rst_seen = 0;
    logic [7:0] cur_pw = 8'h3C;

    always #2 clk = ~clk;

    wdog_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .low_power(low_power), .dbg_enable(dbg_enable), .dbg_suspend(dbg_suspend),
        .dbg_stop(dbg_stop), .count(count), .rst_req(rst_req), .wake(wake),
        .locked(locked), .endinit(endinit), .acc_err(acc_err)
    );

    always @(posedge clk) begin
        if (rst_n && wake) wake_seen++;
        if (rst_n && rst_req) rst_seen++;
    end

    function automatic logic [31:0] mk(input logic [7:0] rel, input logic [7:0] pw,
                                       input logic halt, input logic lk, input logic ei);
        return {8'h00, rel, pw, 5'b0, halt, lk, ei};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [31:0] w);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic tick_n(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic service(input logic [7:0] rel, input logic [7:0] pw,
                           input logic halt, input logic ei);
        wr(mk(8'h00, cur_pw, 1'b0, 1'b0, 1'b0));
        wr(mk(rel, pw, halt, 1'b1, ei));
        cur_pw = pw;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 count", count, 32'hFF00);
        chk("R1 locked", locked, 1);
        chk("R1 endinit", endinit, 1);
        chk("R1 rst_req", rst_req, 0);
        chk("R1 wake", wake, 0);
        chk("R1 acc_err", acc_err, 0);
    endtask

    task automatic t_bad_pw;
        wr(mk(8'h12, 8'h55, 1'b1, 1'b0, 1'b0));
        chk("R3 acc_err", acc_err, 1);
        chk("R3 locked", locked, 1);
        @(negedge clk);
        chk("R3 count", count, 32'hFF00);
        chk("R3 endinit", endinit, 1);
    endtask

    task automatic t_good_pw;
        wr(mk(8'h00, cur_pw, 1'b0, 1'b0, 1'b0));
        chk("R2 locked", locked, 0);
        chk("R2 acc_err", acc_err, 0);
        chk("R2 endinit", endinit, 1);
        @(negedge clk);
        chk("R2 count", count, 32'hFF00);
    endtask

    task automatic t_modify;
        wr(mk(8'h7F, cur_pw, 1'b0, 1'b1, 1'b0));
        chk("R4 locked", locked, 1);
        chk("R4 endinit", endinit, 0);
        @(negedge clk);
        chk("R4 count reload", count, 32'h7F00);
    endtask

    task automatic t_count;
        tick_n(5);
        chk("R6 count five ticks", count, 32'h7F05);
        repeat (3) @(negedge clk);
        chk("R6 hold without tick", count, 32'h7F05);
    endtask

    task automatic t_wake;
        int w0;
        tick_n(250);
        chk("R8 at midpoint", count, 32'h7FFF);
        low_power = 1'b1;
        tick_n(1);
        chk("R8 wake pulse", wake, 1);
        chk("R8 count after midpoint", count, 32'h8000);
        @(negedge clk);
        chk("R8 wake one cycle", wake, 0);
        low_power = 1'b0;
        service(8'h7F, cur_pw, 1'b0, 1'b0);
        w0 = wake_seen;
        tick_n(256);
        repeat (2) @(negedge clk);
        chk("R8 count crossed", count, 32'h8000);
        chk("R8 no wake without low_power", wake_seen, w0);
    endtask

    task automatic t_overflow;
        service(8'hFF, cur_pw, 1'b0, 1'b0);
        tick_n(255);
        chk("R7 at top", count, 32'hFFFF);
        chk("R7 no early reset", rst_req, 0);
        tick_n(1);
        chk("R7 rst_req", rst_req, 1);
        chk("R7 reload after overflow", count, 32'hFF00);
        @(negedge clk);
        chk("R7 rst_req one cycle", rst_req, 0);
    endtask

    task automatic t_halt;
        int r0;
        service(8'hFE, cur_pw, 1'b1, 1'b0);
        chk("R4 reload while halted", count, 32'hFE00);
        r0 = rst_seen;
        tick_n(600);
        chk("R9 halted count", count, 32'hFE00);
        dbg_enable = 1'b1;
        tick_n(5);
        dbg_enable = 1'b0;
        @(negedge clk);
        chk("R9 halted with debug", count, 32'hFE00);
        chk("R9 no reset while halted", rst_seen, r0);
    endtask

    task automatic t_debug;
        service(8'h10, cur_pw, 1'b0, 1'b0);
        dbg_enable = 1'b1; dbg_suspend = 1'b1; dbg_stop = 1'b1;
        tick_n(10);
        chk("R10 suspended", count, 32'h1000);
        dbg_stop = 1'b0;
        tick_n(3);
        chk("R10 stop line low runs", count, 32'h1003);
        dbg_suspend = 1'b0; dbg_stop = 1'b1;
        tick_n(4);
        chk("R10 suspend low runs", count, 32'h1007);
        dbg_enable = 1'b0; dbg_suspend = 1'b1;
        tick_n(2);
        chk("R10 session off runs", count, 32'h1009);
        dbg_suspend = 1'b0; dbg_stop = 1'b0;
    endtask

    task automatic t_bad_modify;
        wr(mk(8'h00, cur_pw, 1'b0, 1'b0, 1'b0));
        chk("R5 unlocked", locked, 0);
        wr(mk(8'h22, 8'h99, 1'b1, 1'b0, 1'b1));
        chk("R5 acc_err", acc_err, 1);
        chk("R5 relocked", locked, 1);
        chk("R5 endinit kept", endinit, 0);
        @(negedge clk);
        chk("R5 count kept", count, 32'h1009);
        wr(mk(8'h00, cur_pw, 1'b0, 1'b0, 1'b0));
        chk("R5 password kept", locked, 0);
    endtask

    task automatic t_new_pw;
        wr(mk(8'h10, 8'hA5, 1'b0, 1'b1, 1'b0));
        @(negedge clk);
        chk("R4 reload", count, 32'h1000);
        wr(mk(8'h00, 8'h3C, 1'b0, 1'b0, 1'b0));
        chk("R4 old password rejected", acc_err, 1);
        chk("R4 still locked", locked, 1);
        wr(mk(8'h00, 8'hA5, 1'b0, 1'b0, 1'b0));
        chk("R4 new password accepted", locked, 0);
        wr(mk(8'h10, 8'hA5, 1'b0, 1'b1, 1'b0));
        cur_pw = 8'hA5;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bad_pw();
        t_good_pw();
        t_modify();
        t_count();
        t_wake();
        t_overflow();
        t_halt();
        t_debug();
        t_bad_modify();
        t_new_pw();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule